// File: doc/BRIEF.md
# PLL Power-Up and Retune Sequencer

This block steps the control bits of a single PLL through its power-up, power-down and frequency-change procedures. A requester presents one of three commands (power up, power down, retune) on a valid/ready handshake. The sequencer then drives the power-on, isolation, enable and reset-release bits in a fixed order. It also drives the post-divider code and the feedback control word, together with a one-cycle change strobe. Every wait is a whole number of microseconds, converted to clock cycles through a cycles-per-microsecond parameter.

The power-up sequence has four steps. Power-on is raised first. Isolation is released one microsecond later. The PLL enable is raised after a second microsecond. The reset-release bit is raised after a further twenty microseconds, on builds that have that bit. Power-down takes one cycle per step in the reverse order and has no dwell. A retune writes the post-divider and the control word, pulses the change strobe, then waits twenty microseconds of settle time before it accepts another command. A build parameter says whether the post-divider and the control word sit in one register (written together) or in two (post-divider one cycle first).

States: `ST_IDLE`; power-up `ST_UP_PWR`, `ST_UP_ISO`, `ST_UP_ENA`, `ST_UP_RSTB`; power-down `ST_DN_RSTB`, `ST_DN_ENA`, `ST_DN_ISO`, `ST_DN_PWR`; retune `ST_TN_DIV`, `ST_TN_WORD`, `ST_TN_SETTLE`.

Transitions:
- `ST_IDLE` goes to `ST_UP_PWR` on an accepted power-up command.
- `ST_IDLE` goes to `ST_DN_RSTB` on an accepted power-down command, or to `ST_DN_ENA` on builds without reset-release.
- `ST_IDLE` goes to `ST_TN_DIV` on an accepted retune command, or to `ST_TN_WORD` in shared-register builds.
- An accepted no-op command leaves the sequencer in `ST_IDLE`.
- Each wait state moves on when its dwell timer reaches zero: `ST_UP_PWR` to `ST_UP_ISO`, `ST_UP_ISO` to `ST_UP_ENA`, and `ST_UP_ENA` to `ST_UP_RSTB` (or to `ST_IDLE` without reset-release). `ST_TN_SETTLE` goes to `ST_IDLE`.
- These states last one cycle each: `ST_UP_RSTB` to `ST_IDLE`, `ST_DN_RSTB` to `ST_DN_ENA`, `ST_DN_ENA` to `ST_DN_ISO`, `ST_DN_ISO` to `ST_DN_PWR`, `ST_DN_PWR` to `ST_IDLE`, and `ST_TN_DIV` to `ST_TN_WORD`. `ST_TN_WORD` goes to `ST_TN_SETTLE`.

Top module: `pll_ctrl_seq`

## Requirements
- R1: After reset, `pwr_ctl` is 2'b10 (bit 0 power-on low, bit 1 isolation high). `pll_en`, `rst_rel`, `div_code` and `word_reg` are all zero, and `req_ready` is high.
- R2: A power-up command is accepted on the clock edge where `req_valid` and `req_ready` are both high, with `req_cmd` = 2'd1. On that edge `pwr_ctl[0]` rises. `pwr_ctl[1]` falls exactly `US_CYC*PWR_US` cycles later.
- R3: `pll_en` rises exactly `US_CYC*(PWR_US+ISO_US)` cycles after a power-up command is accepted.
- R4: With `HAS_RST_REL`=1, `rst_rel` rises `US_CYC*(PWR_US+ISO_US+ENA_US)` cycles after acceptance, and `req_ready` returns one cycle after that.
- R5: A power-down command (`req_cmd` = 2'd2) takes one cycle per step in this order. `rst_rel` falls on the accept edge. `pll_en` falls on the next edge. Isolation rises on the edge after that, then power-on falls. `req_ready` returns one cycle after the last step.
- R6: A retune command (`req_cmd` = 2'd3) with `SHARED_REG`=0 writes `div_code` on the accept edge. It writes `word_reg[PCW_W-1:0]` on the next edge, with `word_reg[31]` (change strobe) high for exactly one cycle.
- R7: With `SHARED_REG`=1, a retune writes `div_code`, the control word and the strobe bit 31 on the accept edge.
- R8: With `HAS_RST_REL`=0, `rst_rel` never rises. `req_ready` returns `US_CYC*(PWR_US+ISO_US+ENA_US)` cycles after a power-up command is accepted. Power-down starts by clearing `pll_en` on the accept edge.
- R9: After the strobe cycle, `req_ready` stays low for `US_CYC*SETTLE_US` cycles and is then high again.
- R10: While a sequence runs, `req_ready` is low. A request held on `req_valid` is not lost: it is accepted on the first edge after `req_ready` returns, and then carried out.
- R11: An accepted no-op (`req_cmd` = 2'd0) changes no output, and `req_ready` stays high.
- R12: Isolation is released only while power-on is high. `pll_en` is high only while powered and released from isolation. `rst_rel` is high only while `pll_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Sequencer idle; request accepted when both high |
| req_cmd | input | 2 | 0 no-op, 1 power up, 2 power down, 3 retune |
| req_div | input | PDIV_W | Post-divider code (log2 of the divide ratio) for retune |
| req_word | input | PCW_W | Feedback control word for retune |
| pwr_ctl | output | 2 | Bit 0 power-on, bit 1 isolation |
| pll_en | output | 1 | PLL enable |
| rst_rel | output | 1 | Reset release (active high) |
| div_code | output | PDIV_W | Applied post-divider code |
| word_reg | output | 32 | Bit 31 change strobe, low PCW_W bits control word |

## Verification
All outputs are registered, so every result is due a whole number of clock edges after the accept edge. Power-on and the first write of a retune or power-down are due on that accept edge. The later power-down steps follow on successive edges. The isolation release, enable and reset release come `US_CYC` times 1, 2 and 22 edges in. `req_ready` returns a fixed count of edges after the accept edge, and that count depends on the build options. The bench drives and samples on the falling edge. It counts edges from the accept edge, checks each output on the last cycle before its change and on the cycle of the change, and measures the number of cycles a held request waits.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_UP   = 2'd1,
        CMD_DOWN = 2'd2,
        CMD_TUNE = 2'd3
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_PWR,
        ST_UP_ISO,
        ST_UP_ENA,
        ST_UP_RSTB,
        ST_DN_RSTB,
        ST_DN_ENA,
        ST_DN_ISO,
        ST_DN_PWR,
        ST_TN_DIV,
        ST_TN_WORD,
        ST_TN_SETTLE
    } state_e;

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pllseq_tune_path.sv
module pllseq_tune_path #(
    parameter int PDIV_W     = 3,
    parameter int PCW_W      = 22,
    parameter bit SHARED_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [PDIV_W-1:0] in_div,
    input  logic [PCW_W-1:0]  in_word,
    input  logic              wr_div,
    input  logic              wr_word,
    output logic [PDIV_W-1:0] div_q,
    output logic [PCW_W-1:0]  word_q
);
    logic [PCW_W-1:0] word_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_div) begin
            div_q <= in_div;
        end
    end

    generate
        if (SHARED_REG) begin : g_shared
            // Word is written on the accept edge straight from the request.
            assign word_src = in_word;
        end else begin : g_split
            logic [PCW_W-1:0] hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (capture) begin
                    hold_q <= in_word;
                end
            end
            assign word_src = hold_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_word) begin
            word_q <= word_src;
        end
    end
endmodule

// File: rtl/pll_ctrl_seq.sv
module pll_ctrl_seq
    import pllseq_pkg::*;
#(
    parameter int US_CYC      = 125,
    parameter int PWR_US      = 1,
    parameter int ISO_US      = 1,
    parameter int ENA_US      = 20,
    parameter int SETTLE_US   = 20,
    parameter int PDIV_W      = 3,
    parameter int PCW_W       = 22,
    parameter bit HAS_RST_REL = 1'b1,
    parameter bit SHARED_REG  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [PDIV_W-1:0] req_div,
    input  logic [PCW_W-1:0]  req_word,
    output logic [1:0]        pwr_ctl,
    output logic              pll_en,
    output logic              rst_rel,
    output logic [PDIV_W-1:0] div_code,
    output logic [31:0]       word_reg
);
    localparam int CYC_PWR    = US_CYC * PWR_US;
    localparam int CYC_ISO    = US_CYC * ISO_US;
    localparam int CYC_ENA    = US_CYC * ENA_US;
    localparam int CYC_SETTLE = US_CYC * SETTLE_US;
    localparam int CYC_MAX12  = (CYC_PWR > CYC_ISO) ? CYC_PWR : CYC_ISO;
    localparam int CYC_MAX34  = (CYC_ENA > CYC_SETTLE) ? CYC_ENA : CYC_SETTLE;
    localparam int CYC_MAX    = (CYC_MAX12 > CYC_MAX34) ? CYC_MAX12 : CYC_MAX34;
    localparam int TW         = $clog2(CYC_MAX + 1);

    state_e state_q, state_d;
    logic   accept, enter, tmr_load, tmr_expired;
    logic   wr_div, wr_word;
    logic   strobe_q;
    logic [TW-1:0]    tmr_val;
    logic [PCW_W-1:0] word_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign enter     = (state_d != state_q);

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_e'(req_cmd))
                        CMD_UP:   state_d = ST_UP_PWR;
                        CMD_DOWN: state_d = HAS_RST_REL ? ST_DN_RSTB : ST_DN_ENA;
                        CMD_TUNE: state_d = SHARED_REG ? ST_TN_WORD : ST_TN_DIV;
                        CMD_NOP:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_UP_PWR:    if (tmr_expired) state_d = ST_UP_ISO;
            ST_UP_ISO:    if (tmr_expired) state_d = ST_UP_ENA;
            ST_UP_ENA:    if (tmr_expired) state_d = HAS_RST_REL ? ST_UP_RSTB : ST_IDLE;
            ST_UP_RSTB:   state_d = ST_IDLE;
            ST_DN_RSTB:   state_d = ST_DN_ENA;
            ST_DN_ENA:    state_d = ST_DN_ISO;
            ST_DN_ISO:    state_d = ST_DN_PWR;
            ST_DN_PWR:    state_d = ST_IDLE;
            ST_TN_DIV:    state_d = ST_TN_WORD;
            ST_TN_WORD:   state_d = ST_TN_SETTLE;
            ST_TN_SETTLE: if (tmr_expired) state_d = ST_IDLE;
        endcase
    end

    // Dwell timer is loaded on entry to each waiting state.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (enter) begin
            unique case (state_d)
                ST_UP_PWR:    begin tmr_load = 1'b1; tmr_val = TW'(CYC_PWR - 1);    end
                ST_UP_ISO:    begin tmr_load = 1'b1; tmr_val = TW'(CYC_ISO - 1);    end
                ST_UP_ENA:    begin tmr_load = 1'b1; tmr_val = TW'(CYC_ENA - 1);    end
                ST_TN_SETTLE: begin tmr_load = 1'b1; tmr_val = TW'(CYC_SETTLE - 1); end
                default:      begin tmr_load = 1'b0; tmr_val = '0;                  end
            endcase
        end
    end

    assign wr_div  = enter && (state_d == ST_TN_DIV || (SHARED_REG && state_d == ST_TN_WORD));
    assign wr_word = enter && (state_d == ST_TN_WORD);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Control-bit outputs, updated on entry to each step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_ctl  <= 2'b10;
            pll_en   <= 1'b0;
            rst_rel  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wr_word;
            if (enter) begin
                unique case (state_d)
                    ST_UP_PWR:  pwr_ctl[0] <= 1'b1;
                    ST_UP_ISO:  pwr_ctl[1] <= 1'b0;
                    ST_UP_ENA:  pll_en     <= 1'b1;
                    ST_UP_RSTB: rst_rel    <= 1'b1;
                    ST_DN_RSTB: rst_rel    <= 1'b0;
                    ST_DN_ENA:  pll_en     <= 1'b0;
                    ST_DN_ISO:  pwr_ctl[1] <= 1'b1;
                    ST_DN_PWR:  pwr_ctl[0] <= 1'b0;
                    default:    ;
                endcase
            end
        end
    end

    pllseq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pllseq_tune_path #(
        .PDIV_W     (PDIV_W),
        .PCW_W      (PCW_W),
        .SHARED_REG (SHARED_REG)
    ) u_tune (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept && cmd_e'(req_cmd) == CMD_TUNE),
        .in_div  (req_div),
        .in_word (req_word),
        .wr_div  (wr_div),
        .wr_word (wr_word),
        .div_q   (div_code),
        .word_q  (word_q)
    );

    assign word_reg = {strobe_q, {(31 - PCW_W){1'b0}}, word_q};
endmodule

// File: rtl/pllseq_sva.sv
module pllseq_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_cmd,
    input logic [1:0]  pwr_ctl,
    input logic        pll_en,
    input logic        rst_rel,
    input logic [31:0] word_reg
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_iso_needs_pwr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ctl[1] |-> pwr_ctl[0]);

    assert_en_needs_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> (pwr_ctl[0] && !pwr_ctl[1]));

    assert_rel_needs_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rel |-> pll_en);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_reg[31] |=> !word_reg[31]);

    assert_pwr_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ctl[0]) |-> $past(acc && req_cmd == 2'd1));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_cmd != 2'd0) |=> !req_ready);

    assert_nop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_cmd == 2'd0) |=> (req_ready && $stable(pwr_ctl) && $stable(pll_en)
                                      && $stable(rst_rel) && $stable(word_reg)));
endmodule

bind pll_ctrl_seq pllseq_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cmd   (req_cmd),
    .pwr_ctl   (pwr_ctl),
    .pll_en    (pll_en),
    .rst_rel   (rst_rel),
    .word_reg  (word_reg)
);

// File: tb/sim_pll_ctrl_seq.sv
module sim_pll_ctrl_seq;
    localparam int K      = 125;
    localparam int PCW_W  = 22;
    localparam int PDIV_W = 3;
    localparam int NVEC   = 3;

    // Retune vectors: {div code, control word}
    localparam logic [PDIV_W+PCW_W-1:0] VEC [0:NVEC-1] = '{
        {3'd1, 22'h0A5A5A},
        {3'd4, 22'h3FFFFF},
        {3'd7, 22'h000001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld0 = 1'b0, vld1 = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [PDIV_W-1:0] dv = '0;
    logic [PCW_W-1:0]  wd = '0;

    logic rdy0, rdy1, en0, en1, rel0, rel1;
    logic [1:0] pc0, pc1;
    logic [PDIV_W-1:0] dc0, dc1;
    logic [31:0] wr0, wr1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_ctrl_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(vld0), .req_ready(rdy0), .req_cmd(cmd),
        .req_div(dv), .req_word(wd), .pwr_ctl(pc0), .pll_en(en0), .rst_rel(rel0),
        .div_code(dc0), .word_reg(wr0)
    );

    pll_ctrl_seq #(.HAS_RST_REL(1'b0), .SHARED_REG(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(vld1), .req_ready(rdy1), .req_cmd(cmd),
        .req_div(dv), .req_word(wd), .pwr_ctl(pc1), .pll_en(en1), .rst_rel(rel1),
        .div_code(dc1), .word_reg(wr1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a request at a falling edge; return half a cycle after the accept edge.
    task automatic start(input bit which, input logic [1:0] c,
                         input logic [PDIV_W-1:0] d, input logic [PCW_W-1:0] w);
        @(negedge clk);
        cmd = c; dv = d; wd = w;
        if (which) vld1 = 1'b1; else vld0 = 1'b1;
        @(negedge clk);
        vld0 = 1'b0; vld1 = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state, both builds
        chk("R1 pwr_ctl", 32'(pc0), 32'h2);
        chk("R1 en/rel", {30'd0, en0, rel0}, 32'h0);
        chk("R1 word", wr0, 32'h0);
        chk("R1 div", 32'(dc0), 32'h0);
        chk("R1 ready", 32'(rdy0), 32'h1);
        chk("R1 u1 pwr_ctl", 32'(pc1), 32'h2);

        // R11 no-op
        start(1'b0, 2'd0, 3'd5, 22'h12345);
        chk("R11 ready", 32'(rdy0), 32'h1);
        chk("R11 pwr_ctl", 32'(pc0), 32'h2);
        chk("R11 word/div", {wr0[28:0], dc0}, 32'h0);

        // R2 R3 R4 power-up on split build with reset release
        start(1'b0, 2'd1, '0, '0);
        chk("R2 pwr on", 32'(pc0), 32'h3);
        chk("R10 busy", 32'(rdy0), 32'h0);
        step(K - 1);
        chk("R2 iso held", 32'(pc0), 32'h3);
        step(1);
        chk("R2 iso released", 32'(pc0), 32'h1);
        chk("R3 en not yet", 32'(en0), 32'h0);
        step(K - 1);
        chk("R3 en not yet late", 32'(en0), 32'h0);
        step(1);
        chk("R3 en up", 32'(en0), 32'h1);
        step(20 * K - 1);
        chk("R4 rel not yet", 32'(rel0), 32'h0);
        step(1);
        chk("R4 rel up", 32'(rel0), 32'h1);
        chk("R4 still busy", 32'(rdy0), 32'h0);
        step(1);
        chk("R4 ready back", 32'(rdy0), 32'h1);

        // R6 R9 retune vectors, split registers
        for (int i = 0; i < NVEC; i++) begin
            logic [PCW_W-1:0] prev;
            prev = wr0[PCW_W-1:0];
            start(1'b0, 2'd3, VEC[i][PDIV_W+PCW_W-1:PCW_W], VEC[i][PCW_W-1:0]);
            chk("R6 div first", 32'(dc0), 32'(VEC[i][PDIV_W+PCW_W-1:PCW_W]));
            chk("R6 word not yet", wr0, 32'(prev));
            step(1);
            chk("R6 word+strobe", wr0, {1'b1, 9'd0, VEC[i][PCW_W-1:0]});
            step(1);
            chk("R6 strobe drop", 32'(wr0[31]), 32'h0);
            step(20 * K - 1);
            chk("R9 settle busy", 32'(rdy0), 32'h0);
            step(1);
            chk("R9 settle done", 32'(rdy0), 32'h1);
        end

        // R10 hold-off then R5 power-down
        start(1'b0, 2'd3, 3'd2, 22'h00BEEF);
        cmd = 2'd2; vld0 = 1'b1;
        begin
            int w;
            w = 0;
            while (!rdy0) begin
                @(negedge clk);
                w++;
            end
            chk("R10 wait length", 32'(w), 32'(20 * K + 2));
        end
        @(negedge clk);
        vld0 = 1'b0;
        chk("R10 held cmd run / R5 rel off", {30'd0, en0, rel0}, 32'h2);
        step(1);
        chk("R5 en off", {28'd0, pc0, en0, rel0}, 32'h4);
        step(1);
        chk("R5 iso on", 32'(pc0), 32'h3);
        step(1);
        chk("R5 pwr off", 32'(pc0), 32'h2);
        chk("R5 busy", 32'(rdy0), 32'h0);
        step(1);
        chk("R5 ready", 32'(rdy0), 32'h1);

        // R7 shared register build
        start(1'b1, 2'd3, 3'd5, 22'h001234);
        chk("R7 div", 32'(dc1), 32'h5);
        chk("R7 word+strobe", wr1, 32'h8000_1234);
        step(1);
        chk("R7 strobe drop", 32'(wr1[31]), 32'h0);
        step(20 * K - 1);
        chk("R9 shared busy", 32'(rdy1), 32'h0);
        step(1);
        chk("R9 shared ready", 32'(rdy1), 32'h1);

        // R8 no reset-release build
        start(1'b1, 2'd1, '0, '0);
        step(22 * K - 1);
        chk("R8 busy", 32'(rdy1), 32'h0);
        chk("R8 en up", 32'(en1), 32'h1);
        step(1);
        chk("R8 ready", 32'(rdy1), 32'h1);
        chk("R8 rel never", 32'(rel1), 32'h0);
        start(1'b1, 2'd2, '0, '0);
        chk("R8 down en first", {28'd0, pc1, en1, rel1}, 32'h4);
        step(1);
        chk("R8 down iso", 32'(pc1), 32'h3);
        step(1);
        chk("R8 down pwr", 32'(pc1), 32'h2);
        step(1);
        chk("R8 down ready", 32'(rdy1), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule